// File: doc/BRIEF.md
# Tick-Synchronized Register Front End

This block sits between a simple memory-mapped bus and the timekeeping core of a low-power real-time clock. Software writes five configuration registers through it: the time value, the alarm value, the interrupt enables, the prescaler enable and the stopwatch count. None of these writes takes effect when it is issued. The block holds one write in a staging slot, reports it as outstanding, and hands it to the timekeeping core at the next slow tick, which nominally comes once a second. While a write is outstanding, every further write to any of the five registers is silently lost. Software therefore has to poll the outstanding flag before it issues the next write.

The block also owns the interrupt status register and the single interrupt line. Events from the timekeeping core latch into the status bits whether or not they are enabled. A write of ones clears status bits in the same cycle, with no tick synchronization. The interrupt line is a level. It is high whenever a latched status bit meets a committed enable bit.

The block produces a one-cycle load strobe per register, so that the timekeeping core can pick up each committed value as it changes.

Top module: `slowtick_regfile`

## Requirements
- R1: After reset, all five committed registers, all status bits, the outstanding flag, every load strobe and the interrupt line are 0.
- R2: A bus write to address 0 (time), 1 (alarm), 2 (enables), 3 (prescaler enable) or 4 (stopwatch) made with nothing outstanding sets status bit 14 (write outstanding) from the next cycle on. A read of that register keeps returning the old committed value until the commit.
- R3: At the first tick edge after the write, the staged value is committed. From the cycle after that edge the register reads the new value, status bit 15 (write done) is 1, bit 14 is 0, and exactly one load strobe is high, at bit position equal to the register address, for that one cycle.
- R4: Any write to addresses 0 to 4 made while bit 14 is 1 is discarded. This includes a write in the same cycle as the committing tick. Only the first staged value is ever committed.
- R5: A write to address 5 (status) clears, in the same clock edge, each status bit at which the written data has a 1, leaving the other bits alone. It is accepted even while a commit is outstanding, and it disturbs neither bit 14 nor the staged write.
- R6: An event pulse on input bit k (0 stopwatch, 1 alarm, 2 second, 3 minute, 4 hour, 5 day rollover, 6 day alarm) sets status bit k on the next edge, independent of the enable register. The bit stays set until it is cleared.
- R7: The interrupt output is 1 exactly while some status bit among 15 and 6..0 is 1 and the committed enable bit at the same position is 1. It stays 1 for as long as that holds.
- R8: Writing 0xFFFF to the status address clears every clearable status bit. Bit 14 is read-only.
- R9: If an event pulse and a status-clear write hit the same bit on the same edge, the bit ends up set.
- R10: Register bits with no storage read 0. The prescaler enable keeps only bit 0, the stopwatch keeps its low SW_W bits, and the enable register keeps bits 15 and 6..0.
- R11: Writes to addresses 6 and 7 change nothing and start no commit, and reads of those addresses return 0.
- R12: A tick with nothing outstanding produces no load strobe, sets no write-done bit and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow tick strobe, bus clock domain |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational on address) |
| evt_i | input | 7 | Event pulses from the timekeeping core |
| time_q | output | DATA_W | Committed time value |
| alarm_q | output | DATA_W | Committed alarm value |
| ien_q | output | 16 | Committed interrupt enables |
| pren_q | output | 1 | Committed prescaler enable |
| swatch_q | output | SW_W | Committed stopwatch count |
| load_o | output | 5 | One-cycle commit strobe per register |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a write that collides with the very tick that commits the previous write. The write slips into the staging slot a cycle too late, and a wrong design would commit the second value on a later tick. The bench drives the write and the tick in the same cycle for one pattern per register. It then issues an extra idle tick and confirms that the register still holds the first value and that no load strobe fires. A similar collision is forced on the status register, with an event and a clear on the same edge.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
   localparam int NUM_SYNC = 5;
   localparam int NUM_EVT  = 7;
   localparam int BIT_DONE = 15;
   localparam int BIT_BUSY = 14;
   // status bits that have storage (done + events)
   localparam logic [15:0] STAT_IMPL = 16'h807F;

   typedef enum logic [2:0] {
      A_TIME   = 3'd0,
      A_ALARM  = 3'd1,
      A_IEN    = 3'd2,
      A_PREN   = 3'd3,
      A_SWATCH = 3'd4,
      A_STAT   = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/rtcfe_stage.sv
module rtcfe_stage #(
   parameter int DATA_W = 32,
   parameter int NSYNC  = 5,
   localparam int IDX_W = $clog2(NSYNC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   output logic              busy,
   output logic              commit,
   output logic [IDX_W-1:0]  commit_idx,
   output logic [DATA_W-1:0] commit_data
);
   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         data_q <= '0;
      end else if (busy_q) begin
         if (tick) busy_q <= 1'b0;
      end else if (wr_req) begin
         busy_q <= 1'b1;
         idx_q  <= wr_idx;
         data_q <= wr_data;
      end
   end

   assign busy        = busy_q;
   assign commit      = busy_q & tick;
   assign commit_idx  = idx_q;
   assign commit_data = data_q;

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick |=> busy); // R4
   AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(commit_data) && $stable(commit_idx)); // R4
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && tick |=> !busy); // R3
endmodule

// File: rtl/rtcfe_shadow.sv
module rtcfe_shadow
   import rtcfe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SW_W   = 16,
   parameter int NSYNC  = 5,
   localparam int IDX_W = $clog2(NSYNC)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit,
   input  logic [IDX_W-1:0]              commit_idx,
   input  logic [DATA_W-1:0]             commit_data,
   output logic [NSYNC-1:0][DATA_W-1:0]  q,
   output logic [NSYNC-1:0]              load
);
   function automatic logic [DATA_W-1:0] keep_mask(input int idx);
      case (idx)
         2:       keep_mask = DATA_W'(STAT_IMPL);
         3:       keep_mask = DATA_W'(1);
         4:       keep_mask = {DATA_W{1'b1}} >> (DATA_W - SW_W);
         default: keep_mask = {DATA_W{1'b1}};
      endcase
   endfunction

   for (genvar g = 0; g < NSYNC; g++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK = keep_mask(g);
      logic [DATA_W-1:0] r_q;
      logic              ld_q;
      logic              hit;
      assign hit = commit && (commit_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q  <= '0;
            ld_q <= 1'b0;
         end else begin
            ld_q <= hit;
            if (hit) r_q <= commit_data & MASK;
         end
      end
      assign q[g]    = r_q;
      assign load[g] = ld_q;
   end

   AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load)); // R3
   AST_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(q)); // R12
endmodule

// File: rtl/rtcfe_status.sv
module rtcfe_status
   import rtcfe_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt,
   input  logic               done_set,
   input  logic               clr_we,
   input  logic [15:0]        clr_data,
   input  logic               busy,
   input  logic [15:0]        ien,
   output logic [15:0]        stat_word,
   output logic               irq
);
   logic [15:0] sticky_q;
   logic [15:0] set_v;
   logic [15:0] clr_v;
   logic        irq_raw;

   assign set_v = {done_set, 8'b0, evt};
   assign clr_v = clr_we ? clr_data : 16'h0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= ((sticky_q & ~clr_v) | set_v) & STAT_IMPL;
   end

   assign stat_word = sticky_q | (16'(busy) << BIT_BUSY);
   assign irq_raw   = |(sticky_q & ien & STAT_IMPL);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   AST_EVT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
      |evt |=> ((sticky_q[NUM_EVT-1:0] & $past(evt)) == $past(evt))); // R6 R9
   AST_CLR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && !done_set && (evt == '0) |=> ((sticky_q & $past(clr_data)) == 16'h0)); // R5
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_raw && !clr_we |=> irq_raw || !$stable(ien)); // R7
endmodule

// File: rtl/slowtick_regfile.sv
module slowtick_regfile
   import rtcfe_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SW_W    = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [6:0]        evt_i,
   output logic [DATA_W-1:0] time_q,
   output logic [DATA_W-1:0] alarm_q,
   output logic [15:0]       ien_q,
   output logic              pren_q,
   output logic [SW_W-1:0]   swatch_q,
   output logic [4:0]        load_o,
   output logic              irq_o
);
   localparam int IDX_W = $clog2(NUM_SYNC);

   if (DATA_W < 16) begin : g_bad_dw
      $error("DATA_W must be at least 16");
   end
   if (SW_W < 1 || SW_W > DATA_W) begin : g_bad_sw
      $error("SW_W must lie in 1..DATA_W");
   end

   logic                           wr_sync;
   logic                           clr_we;
   logic                           busy;
   logic                           commit;
   logic [IDX_W-1:0]               commit_idx;
   logic [DATA_W-1:0]              commit_data;
   logic [NUM_SYNC-1:0][DATA_W-1:0] sh_q;
   logic [NUM_SYNC-1:0]            sh_load;
   logic [15:0]                    stat_word;

   assign wr_sync = bus_sel && bus_wr && (bus_addr < 3'(NUM_SYNC));
   assign clr_we  = bus_sel && bus_wr && (bus_addr == A_STAT);

   rtcfe_stage #(.DATA_W(DATA_W), .NSYNC(NUM_SYNC)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_req      (wr_sync),
      .wr_idx      (bus_addr[IDX_W-1:0]),
      .wr_data     (bus_wdata),
      .tick        (tick_i),
      .busy        (busy),
      .commit      (commit),
      .commit_idx  (commit_idx),
      .commit_data (commit_data)
   );

   rtcfe_shadow #(.DATA_W(DATA_W), .SW_W(SW_W), .NSYNC(NUM_SYNC)) u_shadow (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .commit_idx  (commit_idx),
      .commit_data (commit_data),
      .q           (sh_q),
      .load        (sh_load)
   );

   rtcfe_status #(.IRQ_REG(IRQ_REG)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_i),
      .done_set  (commit),
      .clr_we    (clr_we),
      .clr_data  (bus_wdata[15:0]),
      .busy      (busy),
      .ien       (sh_q[A_IEN][15:0]),
      .stat_word (stat_word),
      .irq       (irq_o)
   );

   always_comb begin
      case (bus_addr)
         A_TIME:   bus_rdata = sh_q[0];
         A_ALARM:  bus_rdata = sh_q[1];
         A_IEN:    bus_rdata = sh_q[2];
         A_PREN:   bus_rdata = sh_q[3];
         A_SWATCH: bus_rdata = sh_q[4];
         A_STAT:   bus_rdata = DATA_W'(stat_word);
         default:  bus_rdata = '0;
      endcase
   end

   assign time_q   = sh_q[A_TIME];
   assign alarm_q  = sh_q[A_ALARM];
   assign ien_q    = sh_q[A_IEN][15:0];
   assign pren_q   = sh_q[A_PREN][0];
   assign swatch_q = sh_q[A_SWATCH][SW_W-1:0];
   assign load_o   = sh_load;

   AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (load_o == '0)); // R12
   AST_BAD_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && bus_wr && (bus_addr > 3'd5) && !busy |=> !busy); // R11
   AST_PEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sync && !busy |=> stat_word[BIT_BUSY]); // R2
endmodule

// File: tb/test_slowtick_regfile.sv
module test_slowtick_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [6:0]    evt_i = '0;
   logic [DW-1:0] time_q, alarm_q;
   logic [15:0]   ien_q;
   logic          pren_q;
   logic [SW-1:0] swatch_q;
   logic [4:0]    load_o;
   logic          irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [DW-1:0] cur [5];

   always #(CLK_PERIOD/2) clk = ~clk;

   slowtick_regfile #(.DATA_W(DW), .SW_W(SW), .IRQ_REG(1'b0)) i_slowtick_regfile (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
      .time_q(time_q), .alarm_q(alarm_q), .ien_q(ien_q), .pren_q(pren_q),
      .swatch_q(swatch_q), .load_o(load_o), .irq_o(irq_o)
   );

   function automatic logic [DW-1:0] exp_mask(input int r);
      case (r)
         2: exp_mask = 32'h0000_807F;
         3: exp_mask = 32'h0000_0001;
         4: exp_mask = 32'h0000_FFFF;
         default: exp_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic write_with_tick(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_i = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; tick_i = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic pulse_evt(input logic [6:0] e);
      @(negedge clk);
      evt_i = e;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic commit_reg(input logic [2:0] a, input logic [DW-1:0] d);
      bus_write(a, d);
      do_tick();
      cur[a] = d & exp_mask(int'(a));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] v;
      logic [DW-1:0] pat;
      for (int i = 0; i < 5; i++) cur[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R1 reset read", v, '0);
      end
      check("R1 reset irq", 32'(irq_o), 0);
      check("R1 reset load", 32'(load_o), 0);

      // R12 idle tick
      do_tick();
      check("R12 idle load", 32'(load_o), 0);
      rd(3'd5, v);
      check("R12 idle status", v, 0);

      // R2 R3 R4 R10 sweep over registers and patterns
      for (int r = 0; r < 5; r++) begin
         for (int p = 0; p < 4; p++) begin
            pat = (p == 0) ? 32'hFFFF_FFFF : 32'h9E37_79B9 * 32'(r * 4 + p + 1);
            bus_write(3'(r), pat);
            rd(3'd5, v);
            check("R2 pending flag", 32'(v[14]), 1);
            rd(3'(r), v);
            check("R2 old value kept", v, cur[r]);
            if (p == 1) begin
               write_with_tick(3'(r), ~pat);
            end else begin
               bus_write(3'(r), ~pat);
               do_tick();
            end
            check("R3 load strobe", 32'(load_o), 32'(1) << r);
            cur[r] = pat & exp_mask(r);
            rd(3'(r), v);
            check("R3 R10 committed value", v, cur[r]);
            rd(3'd5, v);
            check("R3 done set", 32'(v[15]), 1);
            check("R3 pending cleared", 32'(v[14]), 0);
            do_tick();
            check("R4 no second load", 32'(load_o), 0);
            rd(3'(r), v);
            check("R4 discarded write", v, cur[r]);
            bus_write(3'd5, 32'h8000);
            rd(3'd5, v);
            check("R5 done cleared", 32'(v[15]), 0);
         end
      end

      // quiet enables, clean status
      commit_reg(3'd2, 32'h0);
      bus_write(3'd5, 32'hFFFF);
      rd(3'd5, v);
      check("R8 clear all", v, 0);

      // R11 invalid addresses
      bus_write(3'd6, 32'hFFFF_FFFF);
      bus_write(3'd7, 32'hFFFF_FFFF);
      rd(3'd5, v);
      check("R11 no pending", v, 0);
      rd(3'd6, v);
      check("R11 read 6", v, 0);
      rd(3'd7, v);
      check("R11 read 7", v, 0);
      for (int r = 0; r < 5; r++) begin
         rd(3'(r), v);
         check("R11 regs unchanged", v, cur[r]);
      end

      // R6 events latch with enables off
      for (int b = 0; b < 7; b++) begin
         pulse_evt(7'(1 << b));
         rd(3'd5, v);
         check("R6 event latched", v, (32'(1) << (b + 1)) - 1);
         check("R6 no irq disabled", 32'(irq_o), 0);
      end
      bus_write(3'd5, 32'h0000_0002);
      rd(3'd5, v);
      check("R5 partial clear", v, 32'h7D);
      bus_write(3'd5, 32'hFFFF);
      rd(3'd5, v);
      check("R8 clear all events", v, 0);

      // R7 interrupt combine
      commit_reg(3'd2, 32'h0000_0005);
      bus_write(3'd5, 32'hFFFF);
      pulse_evt(7'h02);
      check("R7 unenabled event", 32'(irq_o), 0);
      pulse_evt(7'h04);
      check("R7 enabled event", 32'(irq_o), 1);
      @(negedge clk);
      check("R7 level held", 32'(irq_o), 1);
      bus_write(3'd5, 32'h4);
      check("R7 cleared drops irq", 32'(irq_o), 0);
      pulse_evt(7'h01);
      check("R7 stopwatch irq", 32'(irq_o), 1);
      commit_reg(3'd2, 32'h0);
      check("R7 enable removed", 32'(irq_o), 0);
      commit_reg(3'd2, 32'h8000);
      check("R7 done bit irq", 32'(irq_o), 1);
      commit_reg(3'd2, 32'h0);
      bus_write(3'd5, 32'hFFFF);

      // R9 event beats same-edge clear
      @(negedge clk);
      evt_i = 7'h04; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'hFFFF;
      @(negedge clk);
      evt_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(3'd5, v);
      check("R9 set wins", v, 32'h4);

      // R5 clear while pending leaves commit intact
      bus_write(3'd1, 32'h0000_0123);
      bus_write(3'd5, 32'hFFFF);
      rd(3'd5, v);
      check("R5 pending survives clear", v, 32'h4000);
      do_tick();
      check("R5 commit still loads", 32'(load_o), 32'h2);
      rd(3'd1, v);
      check("R5 staged value committed", v, 32'h123);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule